// File: doc/BRIEF.md
# Scan-List Acquisition Sequencer

This block controls the analog-input path of a multichannel acquisition board. The host reaches it over a simple 16-bit register bus. The host builds a scan list by writing bytes into a scan-list FIFO. Each channel entry in that list is a record of four 16-bit control words.

A configuration pipe pulls one record at a time out of the FIFO and presents its fields to the front end. A programmable pacer divider then starts conversions. The block talks to the converter through a request/acknowledge handshake. Each returned sample is pushed into a results FIFO, which the host drains by reading one register.

The host drives the block with a command-coded control register and watches a status word. An entry whose record carries the last-entry flag suspends acquisition once its sample is stored. In this way a single-sample read and a multi-entry scan use the same mechanism.

Top module: `acq_seq`

## Requirements
- R1: A scan-list word is written as two writes to address 1, low byte first and high byte second, each taken from bits [7:0]. A word enters the scan-list FIFO only on the second write, so status bit 5 (scan list empty) stays set after the first byte and clears after the second.
- R2: A write to the control register (address 0) whose bits [15:3] are zero is a reset request: bit 0 empties the configuration pipe, bit 1 empties the results FIFO and clears both overrun flags, and bit 2 empties the scan-list FIFO and the byte assembler.
- R3: Control value 0x0011 lets the configuration pipe take words from the scan list, and 0x0010 stops it. Status bit 4 (pipe full) sets once four words are held, and no words are taken while loading is stopped.
- R4: Control value 0x0031 runs the pacer and 0x0030 stops it. The divider is 48 bits: address 2 holds bits [15:0], address 3 holds bits [31:16] and address 4 holds bits [47:32]. With divider N, adc_req first rises on the N-th rising edge after the edge that takes the enable command.
- R5: On a pacer tick with a full pipe and no pending conversion, adc_req rises and stays high until adc_ack. The adc_data value then enters the results FIFO. Status bit 1 shows that the results FIFO holds data, and bit 0 shows that it holds more than one sample.
- R6: When the sample of an entry with bit 2 of its second word set is stored, status bit 3 (scanning) clears and no further conversion starts. A following 0x0011 discards the suspended entry, loads the next one and resumes.
- R7: After the sample of an entry without the last flag is stored, the pipe takes the next entry and scanning stays set.
- R8: A pacer tick while adc_req is high sets status bit 8 (pacer overrun). The bit stays set until a results-FIFO reset (R2 bit 1); a pipe reset leaves it set.
- R9: A read of address 5 returns the oldest sample and removes it, so samples come back in conversion order.
- R10: A sample arriving while the results FIFO is full is dropped, and status bit 2 (results overrun) sets. The bit clears only through R2 bit 1.
- R11: The pipe fields are decoded as follows: cfg_chan_lo is word 2 bits [7:6]; cfg_bank_en is word 3 bits [1:0]; cfg_hilo is word 3 bit 2; cfg_gain is word 3 bits [5:3]; cfg_corr_gain is word 3 bits [12:8]; cfg_last is word 1 bit 2. cfg_entry holds all four words, with word 0 in bits [15:0].
- R12: After reset the status word, read at address 0, is 0x0020, and adc_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops results at address 5) |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data: status at 0, results head at 5 |
| adc_req | output | 1 | Conversion request to the converter |
| adc_ack | input | 1 | Conversion done |
| adc_data | input | 16 | Converted sample |
| cfg_entry | output | 64 | The four words held in the configuration pipe |
| cfg_last | output | 1 | Last-entry flag of the held entry |
| cfg_chan_lo | output | 2 | Low channel select |
| cfg_bank_en | output | 2 | Low/high bank enables |
| cfg_hilo | output | 1 | High/low select |
| cfg_gain | output | 3 | Gain code |
| cfg_corr_gain | output | 5 | Correction-gain bits |

## Verification
The assertions check the following on every cycle:
- Both overrun flags are sticky until a results clear.
- A conversion request is held until it is acknowledged.
- A request appears only while scanning, and only after the pipe was full.
- The more-than-one flag never shows without the has-data flag.

The directed scenarios cover what needs a sequence of events:
- the byte order of scan-list writes;
- the exact pacer delay;
- suspension on the last entry and the resume that follows;
- walking through a multi-entry list in order;
- dropping a sample into a full results FIFO;
- which reset clears which flag.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_SCAN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIV_LL = 3'd2;
    localparam logic [ADDR_W-1:0] A_DIV_LH = 3'd3;
    localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_RESULT = 3'd5;

    localparam logic [15:0] CMD_LOAD_ON  = 16'h0011;
    localparam logic [15:0] CMD_LOAD_OFF = 16'h0010;
    localparam logic [15:0] CMD_PACE_ON  = 16'h0031;
    localparam logic [15:0] CMD_PACE_OFF = 16'h0030;

    localparam int WORDS_PER_ENTRY = 4;

    typedef struct packed {
        logic [WORDS_PER_ENTRY-1:0][15:0] pipe;
        logic [2:0]  pipe_cnt;
        logic [31:0] div_lo;
        logic [15:0] div_hi;
        logic [7:0]  byte_lo;
        logic        byte_phase;
        logic        load_en;
        logic        pacer_en;
        logic        suspended;
        logic        scanning;
        logic        adc_req;
        logic        res_ovr;
        logic        pace_ovr;
    } seq_state_t;
endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) st_d.wp = step(st_q.wp);
        if (do_pop)  st_d.rp = step(st_q.rp);
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[st_q.wp] <= din;
    end

    assign dout  = mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/acq_pacer.sv
module acq_pacer #(
    parameter int DIV_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && ((div <= DIV_W'(1)) || (cnt_q == div - 1'b1));
        cnt_d = cnt_q + 1'b1;
        if (!en || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
    import acq_seq_pkg::*;
#(
    parameter int SL_DEPTH  = 32,
    parameter int RES_DEPTH = 8,
    localparam int SL_CW    = $clog2(SL_DEPTH + 1),
    localparam int RES_CW   = $clog2(RES_DEPTH + 1),
    localparam int DIV_W    = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              adc_req,
    input  logic              adc_ack,
    input  logic [15:0]       adc_data,
    output logic [63:0]       cfg_entry,
    output logic              cfg_last,
    output logic [1:0]        cfg_chan_lo,
    output logic [1:0]        cfg_bank_en,
    output logic              cfg_hilo,
    output logic [2:0]        cfg_gain,
    output logic [4:0]        cfg_corr_gain
);
    seq_state_t s_d, s_q;

    logic              sl_push, sl_pop, sl_clr;
    logic [15:0]       sl_dout;
    logic [SL_CW-1:0]  sl_count;
    logic              res_push, res_pop, res_clr;
    logic [15:0]       res_dout;
    logic [RES_CW-1:0] res_count;
    logic              tick;
    logic [2:0]        rst_bits;
    logic              pipe_full_q, sl_empty, res_full;
    logic [15:0]       status_w;

    assign pipe_full_q = (s_q.pipe_cnt == 3'(WORDS_PER_ENTRY));
    assign sl_empty    = (sl_count == '0);
    assign res_full    = (res_count == RES_CW'(RES_DEPTH));

    acq_fifo #(.W(16), .DEPTH(SL_DEPTH)) u_scan_fifo (
        .clk(clk), .rst_n(rst_n), .clr(sl_clr), .push(sl_push), .pop(sl_pop),
        .din({wdata[7:0], s_q.byte_lo}), .dout(sl_dout), .count(sl_count)
    );

    acq_fifo #(.W(16), .DEPTH(RES_DEPTH)) u_res_fifo (
        .clk(clk), .rst_n(rst_n), .clr(res_clr), .push(res_push), .pop(res_pop),
        .din(adc_data), .dout(res_dout), .count(res_count)
    );

    acq_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .en(s_q.pacer_en),
        .div({s_q.div_hi, s_q.div_lo}), .tick(tick)
    );

    always_comb begin
        s_d      = s_q;
        sl_push  = 1'b0;
        res_push = 1'b0;
        rst_bits = 3'b000;
        if (wr_en && addr == A_CTRL && wdata[15:3] == '0) rst_bits = wdata[2:0];

        // byte assembly of scan-list words
        if (wr_en && addr == A_SCAN) begin
            if (!s_q.byte_phase) begin
                s_d.byte_lo    = wdata[7:0];
                s_d.byte_phase = 1'b1;
            end else begin
                sl_push        = 1'b1;
                s_d.byte_phase = 1'b0;
            end
        end

        // divider registers
        if (wr_en && addr == A_DIV_LL) s_d.div_lo[15:0]  = wdata;
        if (wr_en && addr == A_DIV_LH) s_d.div_lo[31:16] = wdata;
        if (wr_en && addr == A_DIV_HI) s_d.div_hi        = wdata;

        // configuration pipe fill
        sl_pop = s_q.load_en && !pipe_full_q && !sl_empty && !s_q.suspended;
        if (sl_pop) begin
            s_d.pipe[s_q.pipe_cnt[1:0]] = sl_dout;
            s_d.pipe_cnt = s_q.pipe_cnt + 1'b1;
        end

        // conversion start on pacer tick
        if (tick) begin
            if (s_q.adc_req) begin
                s_d.pace_ovr = 1'b1;
            end else if (pipe_full_q && !s_q.suspended) begin
                s_d.adc_req  = 1'b1;
                s_d.scanning = 1'b1;
            end
        end

        // conversion done
        if (s_q.adc_req && adc_ack) begin
            s_d.adc_req = 1'b0;
            res_push    = 1'b1;
            if (res_full) s_d.res_ovr = 1'b1;
            if (s_q.pipe[1][2]) begin
                s_d.scanning  = 1'b0;
                s_d.suspended = 1'b1;
            end else begin
                s_d.pipe_cnt  = '0;
            end
        end

        // commands
        if (wr_en && addr == A_CTRL) begin
            unique case (wdata)
                CMD_LOAD_ON: begin
                    s_d.load_en = 1'b1;
                    if (s_q.suspended) begin
                        s_d.suspended = 1'b0;
                        s_d.pipe_cnt  = '0;
                    end
                end
                CMD_LOAD_OFF: s_d.load_en  = 1'b0;
                CMD_PACE_ON:  s_d.pacer_en = 1'b1;
                CMD_PACE_OFF: s_d.pacer_en = 1'b0;
                default: ;
            endcase
        end

        // one-hot resets
        if (rst_bits[0]) begin
            s_d.pipe_cnt  = '0;
            s_d.suspended = 1'b0;
        end
        if (rst_bits[1]) begin
            s_d.res_ovr  = 1'b0;
            s_d.pace_ovr = 1'b0;
        end
        if (rst_bits[2]) s_d.byte_phase = 1'b0;
        sl_clr  = rst_bits[2];
        res_clr = rst_bits[1];
        res_pop = rd_en && addr == A_RESULT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        status_w    = '0;
        status_w[0] = res_count > RES_CW'(1);
        status_w[1] = res_count != '0;
        status_w[2] = s_q.res_ovr;
        status_w[3] = s_q.scanning;
        status_w[4] = pipe_full_q;
        status_w[5] = sl_empty;
        status_w[8] = s_q.pace_ovr;
        case (addr)
            A_CTRL:   rdata = status_w;
            A_RESULT: rdata = res_dout;
            default:  rdata = '0;
        endcase
    end

    assign adc_req       = s_q.adc_req;
    assign cfg_entry     = s_q.pipe;
    assign cfg_last      = s_q.pipe[1][2];
    assign cfg_chan_lo   = s_q.pipe[2][7:6];
    assign cfg_bank_en   = s_q.pipe[3][1:0];
    assign cfg_hilo      = s_q.pipe[3][2];
    assign cfg_gain      = s_q.pipe[3][5:3];
    assign cfg_corr_gain = s_q.pipe[3][12:8];
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic res_clr,
    input logic pace_ovr,
    input logic res_ovr,
    input logic has_data,
    input logic more_one,
    input logic scanning,
    input logic pipe_full,
    input logic adc_req,
    input logic adc_ack
);
    assert_pace_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pace_ovr && !res_clr) |=> pace_ovr);

    assert_res_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ovr && !res_clr) |=> res_ovr);

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_ack) |=> adc_req);

    assert_count_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        more_one |-> has_data);

    assert_req_while_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req |-> scanning);

    assert_req_after_pipe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_req) |-> $past(pipe_full));
endmodule

bind acq_seq acq_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .res_clr(res_clr),
    .pace_ovr(status_w[8]), .res_ovr(status_w[2]),
    .has_data(status_w[1]), .more_one(status_w[0]),
    .scanning(status_w[3]), .pipe_full(status_w[4]),
    .adc_req(adc_req), .adc_ack(adc_ack)
);

// File: tb/acq_seq_test.sv
`timescale 1ns/1ps
module acq_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        adc_req;
    logic        adc_ack = 1'b0;
    logic [15:0] adc_data = '0;
    logic [63:0] cfg_entry;
    logic        cfg_last, cfg_hilo;
    logic [1:0]  cfg_chan_lo, cfg_bank_en;
    logic [2:0]  cfg_gain;
    logic [4:0]  cfg_corr_gain;

    int checks = 0, errors = 0;
    int stub_lat = 3;
    logic [15:0] stub_next = 16'h1000;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    acq_seq #(.SL_DEPTH(32), .RES_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .adc_req(adc_req), .adc_ack(adc_ack),
        .adc_data(adc_data), .cfg_entry(cfg_entry), .cfg_last(cfg_last),
        .cfg_chan_lo(cfg_chan_lo), .cfg_bank_en(cfg_bank_en), .cfg_hilo(cfg_hilo),
        .cfg_gain(cfg_gain), .cfg_corr_gain(cfg_corr_gain)
    );

    // converter stub
    initial begin
        forever begin
            @(negedge clk);
            if (adc_req && !adc_ack) begin
                repeat (stub_lat - 1) @(negedge clk);
                adc_data = stub_next;
                adc_ack  = 1'b1;
                @(negedge clk);
                adc_ack   = 1'b0;
                stub_next = stub_next + 1'b1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = (a == 3'd5); addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic put_word(input logic [15:0] w);
        bus_wr(3'd1, {8'h00, w[7:0]});
        bus_wr(3'd1, {8'h00, w[15:8]});
    endtask

    task automatic put_entry(input logic [15:0] w1, input logic [15:0] w2, input logic [15:0] w3);
        put_word(16'h0000);
        put_word(w1);
        put_word(w2);
        put_word(w3);
    endtask

    task automatic set_div(input logic [47:0] d);
        bus_wr(3'd2, d[15:0]);
        bus_wr(3'd3, d[31:16]);
        bus_wr(3'd4, d[47:32]);
    endtask

    task automatic wait_status(input logic [15:0] mask, input logic [15:0] val, input int maxc);
        logic [15:0] st;
        for (int i = 0; i < maxc; i++) begin
            bus_rd(3'd0, st);
            if ((st & mask) == val) return;
        end
    endtask

    task automatic t_reset;
        logic [15:0] st;
        bus_rd(3'd0, st);
        chk("R12", "status after reset", st, 16'h0020);
        chk("R12", "adc_req after reset", adc_req, 1'b0);
    endtask

    task automatic t_bytes;
        logic [15:0] st;
        bus_wr(3'd1, 16'h0034);
        bus_rd(3'd0, st);
        chk("R1", "empty after low byte", st[5], 1'b1);
        bus_wr(3'd1, 16'h0012);
        bus_rd(3'd0, st);
        chk("R1", "empty after high byte", st[5], 1'b0);
        bus_wr(3'd0, 16'h0004);
        bus_rd(3'd0, st);
        chk("R2", "scan list reset", st[5], 1'b1);
    endtask

    task automatic t_load_stop;
        logic [15:0] st;
        bus_wr(3'd0, 16'h0007);
        bus_wr(3'd0, 16'h0011);
        bus_wr(3'd0, 16'h0010);
        put_entry(16'h0004, 16'h0000, 16'h0000);
        repeat (8) @(negedge clk);
        bus_rd(3'd0, st);
        chk("R3", "no load while stopped", {st[5], st[4]}, 2'b00);
        bus_wr(3'd0, 16'h0007);
    endtask

    task automatic t_single;
        logic [15:0] st, d, s0;
        int n;
        bus_wr(3'd0, 16'h0007);
        set_div(48'd20);
        put_entry(16'h0004, 16'h0880, 16'hCC1D);
        repeat (6) @(negedge clk);
        bus_rd(3'd0, st);
        chk("R3", "pipe idle before start", st[4], 1'b0);
        bus_wr(3'd0, 16'h0011);
        wait_status(16'h0010, 16'h0010, 20);
        bus_rd(3'd0, st);
        chk("R3", "pipe full and list empty", {st[5], st[4]}, 2'b11);
        chk("R11", "chan lo", cfg_chan_lo, 2'd2);
        chk("R11", "bank", cfg_bank_en, 2'b01);
        chk("R11", "hilo", cfg_hilo, 1'b1);
        chk("R11", "gain", cfg_gain, 3'd3);
        chk("R11", "corr gain", cfg_corr_gain, 5'h0C);
        chk("R11", "last", cfg_last, 1'b1);
        chk("R11", "entry", cfg_entry, 64'hCC1D_0880_0004_0000);
        s0 = stub_next;
        bus_wr(3'd0, 16'h0031);
        n = 0;
        while (!adc_req && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R4", "cycles to first request", n, 20);
        wait_status(16'h0002, 16'h0002, 30);
        bus_rd(3'd0, st);
        chk("R5", "status after one sample", st, 16'h0032);
        chk("R6", "scanning cleared", st[3], 1'b0);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (adc_req) n++;
        end
        chk("R6", "no request while suspended", n, 0);
        bus_rd(3'd5, d);
        chk("R9", "sample value", d, s0);
        bus_rd(3'd0, st);
        chk("R9", "fifo empty after pop", st[1:0], 2'b00);
        put_entry(16'h0004, 16'h0040, 16'h0002);
        bus_wr(3'd0, 16'h0011);
        wait_status(16'h0002, 16'h0002, 60);
        chk("R6", "resumed entry chan", cfg_chan_lo, 2'd1);
        chk("R6", "resumed entry bank", cfg_bank_en, 2'b10);
        bus_rd(3'd5, d);
        chk("R6", "resumed sample", d, s0 + 16'd1);
        bus_wr(3'd0, 16'h0030);
        bus_wr(3'd0, 16'h0010);
    endtask

    task automatic t_multi;
        logic [15:0] st, d, s0;
        bus_wr(3'd0, 16'h0007);
        set_div(48'd10);
        put_entry(16'h0000, 16'h0040, 16'h0001);
        put_entry(16'h0004, 16'h00C0, 16'h0002);
        s0 = stub_next;
        bus_wr(3'd0, 16'h0011);
        bus_wr(3'd0, 16'h0031);
        wait_status(16'h0002, 16'h0002, 60);
        bus_rd(3'd0, st);
        chk("R7", "scanning after first entry", st[3], 1'b1);
        wait_status(16'h0009, 16'h0001, 80);
        bus_rd(3'd0, st);
        chk("R7", "status after two entries", st, 16'h0033);
        chk("R7", "second entry chan", cfg_chan_lo, 2'd3);
        bus_rd(3'd5, d);
        chk("R9", "first sample", d, s0);
        bus_rd(3'd5, d);
        chk("R9", "second sample", d, s0 + 16'd1);
        bus_wr(3'd0, 16'h0030);
        bus_wr(3'd0, 16'h0010);
    endtask

    task automatic t_pacer_ovr;
        logic [15:0] st;
        bus_wr(3'd0, 16'h0007);
        stub_lat = 12;
        set_div(48'd2);
        put_entry(16'h0004, 16'h0000, 16'h0001);
        bus_wr(3'd0, 16'h0011);
        wait_status(16'h0010, 16'h0010, 20);
        bus_wr(3'd0, 16'h0031);
        wait_status(16'h0002, 16'h0002, 60);
        bus_wr(3'd0, 16'h0030);
        bus_rd(3'd0, st);
        chk("R8", "pacer overrun set", st[8], 1'b1);
        bus_wr(3'd0, 16'h0001);
        bus_rd(3'd0, st);
        chk("R8", "overrun kept by pipe reset", st[8], 1'b1);
        chk("R2", "pipe reset", st[4], 1'b0);
        bus_wr(3'd0, 16'h0002);
        bus_rd(3'd0, st);
        chk("R8", "overrun cleared", st[8], 1'b0);
        chk("R2", "results reset", st[1], 1'b0);
        stub_lat = 3;
        bus_wr(3'd0, 16'h0010);
    endtask

    task automatic t_res_ovr;
        logic [15:0] st, d, s0;
        bus_wr(3'd0, 16'h0007);
        set_div(48'd8);
        for (int e = 0; e < 4; e++) put_entry(16'h0000, 16'h0000, 16'h0001);
        put_entry(16'h0004, 16'h0000, 16'h0001);
        s0 = stub_next;
        bus_wr(3'd0, 16'h0011);
        bus_wr(3'd0, 16'h0031);
        repeat (300) @(negedge clk);
        bus_rd(3'd0, st);
        chk("R10", "overrun and full", {st[3], st[2:0]}, 4'b0111);
        for (int i = 0; i < 4; i++) begin
            bus_rd(3'd5, d);
            chk("R10", "kept sample", d, s0 + 16'(i));
        end
        bus_rd(3'd0, st);
        chk("R10", "overrun sticky after drain", st[2:0], 3'b100);
        bus_wr(3'd0, 16'h0002);
        bus_rd(3'd0, st);
        chk("R10", "overrun cleared", st[2], 1'b0);
        bus_wr(3'd0, 16'h0030);
        bus_wr(3'd0, 16'h0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_bytes;
        t_load_stop;
        t_single;
        t_multi;
        t_pacer_ovr;
        t_res_ovr;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule